// File: doc/BRIEF.md
# Serial Slave Receive Gate

This block decides when a serial slave port running in four-wire mode may shift in an incoming character. A software enable bit and an active-low slave-select pin together open the receive path. Once the path is open, rising edges of the external serial clock move data bits into an 8-bit shift register, most significant bit first. When the eighth bit arrives, the block copies the character into a receive buffer and raises a receive-ready flag. If the previous character has not been read, it also raises an overrun flag.

The serial clock, slave select and data pins come from a foreign clock domain. Each passes through a two-stage synchronizer, and clock edges are detected in the system domain. A controller with four states sequences the work: off, idle (ready to receive), collecting and servicing. The asynchronous power-up reset and the synchronous software reset both put the controller in the off state, and only the enable bit moves it out of that state.

Top module: `srx_gate`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a cycle with `soft_rst` high, `ctrl_state` is 0 (off), `rx_flag` and `ovr_flag` are 0 and `rx_data` is 0. A character that was partly received is discarded.
- R2: In the off state (0), `rx_en` = 1 moves `ctrl_state` to idle (1) on the next clock. In idle, `rx_en` = 0 returns it to off on the next clock.
- R3: No bit is taken and no character completes in either of these cases: the controller is off, or it is idle with `rx_en` = 0. Rising serial clock edges while `sel_n` is high are also ignored.
- R4: A character is 8 bits. Each bit is taken from `sdi` on a rising edge of `sck` while `sel_n` is low, and the first bit taken becomes bit 7 of `rx_data`.
- R5: The first accepted edge moves the controller from idle to collecting (2). The eighth accepted edge moves it to servicing (3) for exactly one cycle. From servicing it goes to idle if `rx_en` = 1, or to off if `rx_en` = 0.
- R6: Clearing `rx_en` while collecting does not abort the character. The character is still completed and delivered.
- R7: On completion `rx_data` is loaded and `rx_flag` is set. A one-cycle `rd_strobe` clears `rx_flag` on the next clock. If a completion and a read fall in the same cycle, the set wins.
- R8: If a character completes while `rx_flag` is still set and no read is in progress, `ovr_flag` is set and `rx_data` takes the new character.
- R9: Raising `sel_n` in the middle of a character pauses it. Edges seen while it is high are not counted, and the character resumes when `sel_n` returns low.
- R10: A rising edge on the `sck` pin is acted on at the third clock edge after the change. A change of `rx_en` takes effect at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low; asserted asynchronously, released synchronously |
| soft_rst | input | 1 | Synchronous software reset |
| rx_en | input | 1 | Software receive enable |
| sel_n | input | 1 | Slave select pin, active low, asynchronous |
| sck | input | 1 | External serial clock pin, asynchronous |
| sdi | input | 1 | Serial data pin, asynchronous |
| rd_strobe | input | 1 | One-cycle pulse when software reads the buffer |
| rx_data | output | 8 | Receive buffer |
| rx_flag | output | 1 | Character ready |
| ovr_flag | output | 1 | Overrun |
| ctrl_state | output | 2 | 0 off, 1 idle, 2 collecting, 3 servicing |

## Verification
Each result is due at a fixed point after its stimulus:
- A change on a serial pin reaches the controller through two synchronizer flops and is acted on at the third clock edge.
- A change of `rx_en` or `soft_rst` is acted on at the first clock edge.
- A read clears `rx_flag` one edge after the strobe.

The bench drives on falling edges and samples on falling edges. It counts the exact number of edges before the edge-latency and servicing-state checks. Every serial clock phase lasts four clocks, so data and flags have settled when they are compared. All 256 character values are swept, and the expected value of each is the value sent.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_IDLE    = 2'd1,
    ST_COLLECT = 2'd2,
    ST_SERVICE = 2'd3
  } rx_state_e;
endpackage

// File: rtl/srx_reset_sync.sv
module srx_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srx_pin_sync.sv
module srx_pin_sync #(
  parameter int unsigned          WIDTH   = 3,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     IDLE_LV = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= IDLE_LV;
        else        stage_q[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= IDLE_LV;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LV;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/srx_ctrl_fsm.sv
module srx_ctrl_fsm
  import srx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_rst,
  input  logic      rx_en,
  input  logic      sel_act,
  input  logic      sck_rise,
  input  logic      char_done,
  output rx_state_e state_o,
  output logic      shift_en
);
  rx_state_e state_q, state_d;

  always_comb begin
    shift_en = sck_rise && sel_act &&
               (((state_q == ST_IDLE) && rx_en) || (state_q == ST_COLLECT));
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     if (rx_en) state_d = ST_IDLE;
      ST_IDLE: begin
        if (!rx_en)        state_d = ST_OFF;
        else if (shift_en) state_d = ST_COLLECT;
      end
      ST_COLLECT: if (char_done) state_d = ST_SERVICE;
      ST_SERVICE: state_d = rx_en ? ST_IDLE : ST_OFF;
      default:    state_d = ST_OFF;
    endcase
    if (soft_rst) state_d = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R1: software reset always lands in the off state
  a_r1_soft_rst_off: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> state_q == ST_OFF);
  // R3: nothing is shifted while off
  a_r3_off_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |-> !shift_en);
  // R5: servicing lasts exactly one cycle
  a_r5_service_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SERVICE) |=> state_q != ST_SERVICE);
  // R5: servicing is entered only from collecting
  a_r5_service_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_SERVICE) |-> $past(state_q) == ST_COLLECT);
  // R2: off is left only toward idle
  a_r2_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |=> (state_q == ST_OFF) || (state_q == ST_IDLE));
endmodule

// File: rtl/srx_shift_core.sv
module srx_shift_core #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              shift_en,
  input  logic              sdi_bit,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_flag,
  output logic              ovr_flag,
  output logic              char_done
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-2:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              flag_q, flag_d;
  logic              ovr_q, ovr_d;

  assign char_done = shift_en && (cnt_q == LAST);

  always_comb begin
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    buf_d   = buf_q;
    flag_d  = flag_q;
    ovr_d   = ovr_q;
    if (rd_strobe) begin
      flag_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (shift_en) begin
      if (char_done) begin
        cnt_d = '0;
        buf_d = {shreg_q, sdi_bit};
        flag_d = 1'b1;
        if (flag_q && !rd_strobe) ovr_d = 1'b1;
      end else begin
        cnt_d   = cnt_q + 1'b1;
        shreg_d = {shreg_q[DATA_W-3:0], sdi_bit};
      end
    end
    if (soft_rst) begin
      cnt_d   = '0;
      shreg_d = '0;
      buf_d   = '0;
      flag_d  = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      buf_q   <= '0;
      flag_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      buf_q   <= buf_d;
      flag_q  <= flag_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rx_data  = buf_q;
  assign rx_flag  = flag_q;
  assign ovr_flag = ovr_q;

  // R7: a completed character always raises the ready flag
  a_r7_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !soft_rst) |=> flag_q);
  // R7: a read with no completion clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_done) |=> !flag_q);
  // R8: completion over an unread character flags overrun
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && flag_q && !rd_strobe && !soft_rst) |=> ovr_q);
  // R4: the bit counter moves only on an accepted edge
  a_r4_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !soft_rst) |=> $stable(cnt_q));
endmodule

// File: rtl/srx_gate.sv
module srx_gate
  import srx_pkg::*;
#(
  parameter int unsigned DATA_W      = CHAR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              rx_en,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_flag,
  output logic              ovr_flag,
  output logic [1:0]        ctrl_state
);
  localparam int unsigned PINS = 3;
  localparam logic [PINS-1:0] PIN_IDLE = 3'b010;  // {sdi, sel_n, sck}

  logic            rst_sync_n;
  logic [PINS-1:0] pins_sync, pins_rise;
  logic            shift_en, char_done;
  rx_state_e       state;

  srx_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srx_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .IDLE_LV(PIN_IDLE)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  ({sdi, sel_n, sck}),
    .sync_o (pins_sync),
    .rise_o (pins_rise)
  );

  srx_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .soft_rst  (soft_rst),
    .rx_en     (rx_en),
    .sel_act   (!pins_sync[1]),
    .sck_rise  (pins_rise[0]),
    .char_done (char_done),
    .state_o   (state),
    .shift_en  (shift_en)
  );

  srx_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .soft_rst  (soft_rst),
    .shift_en  (shift_en),
    .sdi_bit   (pins_sync[2]),
    .rd_strobe (rd_strobe),
    .rx_data   (rx_data),
    .rx_flag   (rx_flag),
    .ovr_flag  (ovr_flag),
    .char_done (char_done)
  );

  assign ctrl_state = state;

  // R3 / R9: a deselected slave never accepts a bit
  a_r9_sel_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pins_sync[1] |-> !shift_en);
  // R6: completion can only come from an accepted edge
  a_r6_done_needs_shift: assert property (@(posedge clk) disable iff (!rst_sync_n)
    char_done |-> shift_en);
endmodule

// File: tb/srx_gate_bench.sv
module srx_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n, soft_rst, rx_en, sel_n, sck, sdi, rd_strobe;
  logic [7:0] rx_data;
  logic       rx_flag, ovr_flag;
  logic [1:0] ctrl_state;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  srx_gate u_srx_gate (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_en(rx_en),
    .sel_n(sel_n), .sck(sck), .sdi(sdi), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_flag(rx_flag), .ovr_flag(ovr_flag),
    .ctrl_state(ctrl_state)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sck_bit(input logic b);
    sdi = b; sck = 1'b0; tick(4);
    sck = 1'b1; tick(4);
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) sck_bit(v[i]);
    tick(4);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1; tick(1);
    rd_strobe = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; rx_en = 1'b0; sel_n = 1'b1;
    sck = 1'b0; sdi = 1'b0; rd_strobe = 1'b0;
    tick(3);
    check("R1 reset state", {30'd0, ctrl_state}, 0);
    check("R1 reset flags", {30'd0, rx_flag, ovr_flag}, 0);
    check("R1 reset data", {24'd0, rx_data}, 0);
    rst_n = 1'b1; tick(4);

    // R3: clocking while off is ignored
    sel_n = 1'b0; tick(4);
    send_bits(8'hA5, 7, 0);
    check("R3 off state kept", {30'd0, ctrl_state}, 0);
    check("R3 off no flag", {31'd0, rx_flag}, 0);

    // R2 and R10: enable takes effect at the first edge
    rx_en = 1'b1; tick(1);
    check("R2 R10 enable to idle", {30'd0, ctrl_state}, 1);
    rx_en = 1'b0; tick(1);
    check("R2 disable to off", {30'd0, ctrl_state}, 0);
    rx_en = 1'b1; tick(1);

    // R3 / R9: deselected slave ignores clocks
    sel_n = 1'b1; tick(4);
    send_bits(8'hFF, 7, 0);
    check("R3 deselected idle", {30'd0, ctrl_state}, 1);
    check("R3 deselected no flag", {31'd0, rx_flag}, 0);
    sel_n = 1'b0; tick(4);

    // R10: edge acted on at the third clock; R5 service then idle
    sdi = 1'b1; sck = 1'b1; tick(2);
    check("R10 not yet collecting", {30'd0, ctrl_state}, 1);
    tick(1);
    check("R10 R5 collecting", {30'd0, ctrl_state}, 2);
    tick(1); sck = 1'b0; tick(4);
    send_bits(8'hB6, 6, 1);
    sdi = 1'b0; sck = 1'b1; tick(3);
    check("R5 servicing", {30'd0, ctrl_state}, 3);
    tick(1);
    check("R5 back to idle", {30'd0, ctrl_state}, 1);
    tick(1); sck = 1'b0; tick(4);
    check("R4 R10 first char", {24'd0, rx_data}, 8'hB6);
    do_read();

    // R4 R7: exhaustive sweep of character values
    for (int v = 0; v < 256; v++) begin
      send_bits(v[7:0], 7, 0);
      check("R4 data", {24'd0, rx_data}, v);
      check("R7 flag set", {31'd0, rx_flag}, 1);
      check("R8 no overrun", {31'd0, ovr_flag}, 0);
      check("R5 idle after char", {30'd0, ctrl_state}, 1);
      do_read();
      check("R7 read clears", {31'd0, rx_flag}, 0);
    end

    // R8: overrun on unread buffer
    send_bits(8'h3C, 7, 0);
    send_bits(8'hC3, 7, 0);
    check("R8 overrun set", {31'd0, ovr_flag}, 1);
    check("R8 data overwritten", {24'd0, rx_data}, 8'hC3);
    do_read();
    check("R8 overrun cleared by read", {31'd0, ovr_flag}, 0);

    // R9: pause on deselect mid-character
    send_bits(8'h96, 7, 5);
    sel_n = 1'b1; tick(4);
    sck_bit(1'b1); sck_bit(1'b0); sck_bit(1'b1); tick(4);
    check("R9 still collecting", {30'd0, ctrl_state}, 2);
    sel_n = 1'b0; tick(4);
    send_bits(8'h96, 4, 0);
    check("R9 resumed char", {24'd0, rx_data}, 8'h96);
    check("R9 flag", {31'd0, rx_flag}, 1);
    do_read();

    // R6 R5: disable mid-character completes, then off
    send_bits(8'h5A, 7, 4);
    rx_en = 1'b0;
    send_bits(8'h5A, 3, 0);
    check("R6 char delivered", {24'd0, rx_data}, 8'h5A);
    check("R5 off after service", {30'd0, ctrl_state}, 0);
    do_read();

    // R1: software reset mid-character
    rx_en = 1'b1; tick(1);
    send_bits(8'h11, 7, 0);
    send_bits(8'hE7, 7, 4);
    soft_rst = 1'b1; tick(1);
    soft_rst = 1'b0;
    check("R1 soft reset off", {30'd0, ctrl_state}, 0);
    check("R1 soft reset flags", {30'd0, rx_flag, ovr_flag}, 0);
    check("R1 soft reset data", {24'd0, rx_data}, 0);
    tick(1);
    check("R2 leave off by enable", {30'd0, ctrl_state}, 1);
    send_bits(8'h81, 7, 0);
    check("R1 counter restarted", {24'd0, rx_data}, 8'h81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule